// File: doc/BRIEF.md
# TMDS Clock PLL Configuration Selector

This block sizes up the TMDS clock that a video receiver is handed and picks the PLL settings the receiver needs to lock to it. A free-running counter in the TMDS domain is sampled through a Gray-coded synchronizer. Every window of a fixed number of reference cycles, the block takes the difference between two samples. That difference is the TMDS frequency, in units of `REF_KHZ / WINDOW` kHz.

The measured count goes to a range map for the PLL kind the receiver uses. The kind is either a per-channel PLL or a PLL shared by a quad of channels. The map returns a reference divider, a VCO multiplier and a line rate for the oversampling recovery path. Frequencies below the lowest native range turn on that recovery path. Frequencies that land in a VCO gap, or above the top range, are flagged unsupported. Each result is registered, announced with a one-cycle pulse and then held until the next window ends.

The block also checks the static PLL assignment. If transmit and receive share one PLL kind without a bonding request, it raises a conflict. If they are bonded on purpose, any result that needs the recovery path is marked as not usable for transmit.

Top module: `tmds_pll_select`

## Requirements
- R1: While reset is held and until the first window ends: `cfg_valid`=0, `freq_count`=0, `unsupported`=1, `dru_en`=0, `vco_mult`=0, `ref_div`=1, `dru_rate_mbps`=0.
- R2: At the end of every window of `WINDOW` reference cycles, `freq_count` takes the number of TMDS rising edges counted in that window, within ±2. `cfg_valid` is high for exactly one reference cycle per window. All result outputs keep their value between pulses.
- R3: With the channel PLL selected (`rx_pll_sel`=0), a frequency below 80 MHz gives `dru_en`=1, `ref_div`=2, `vco_mult`=20 and `dru_rate_mbps`=2500.
- R4: With the channel PLL, 80 MHz up to but not including 165 MHz gives `ref_div`=1 and `vco_mult`=20. 165 MHz up to but not including 330 MHz gives `ref_div`=1 and `vco_mult`=10. A boundary frequency belongs to the higher range.
- R5: With the channel PLL, 330 MHz and above gives `unsupported`=1.
- R6: With the quad PLL (`rx_pll_sel`=1) and `ref_div`=1, the valid ranges are [74.125, 100) MHz with `vco_mult`=80, [148.25, 200) MHz with `vco_mult`=40 and [296.5, 400) MHz with `vco_mult`=20.
- R7: With the quad PLL, the gaps [100, 148.25) MHz and [200, 296.5) MHz give `unsupported`=1, and so does any frequency of 400 MHz or more.
- R8: With the quad PLL, a frequency below 74.125 MHz gives `dru_en`=1, `ref_div`=1, `vco_mult`=40 and `dru_rate_mbps`=2000.
- R9: Whenever `unsupported`=1, the outputs also read `vco_mult`=0, `dru_en`=0 and `dru_rate_mbps`=0. Whenever it is 0, `vco_mult` is non-zero.
- R10: `sel_conflict` is 1 exactly when `tx_pll_sel` equals `rx_pll_sel` and `bond_req` is 0.
- R11: `tx_dru_reject` is 1 exactly when `tx_pll_sel` equals `rx_pll_sel`, `bond_req` is 1 and `dru_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fixed reference clock of `REF_KHZ` kHz |
| rst_n | input | 1 | Active-low asynchronous reset, both domains |
| clk_tmds | input | 1 | TMDS clock being measured |
| rx_pll_sel | input | 1 | Receive PLL kind: 0 channel, 1 quad |
| tx_pll_sel | input | 1 | Transmit PLL kind: 0 channel, 1 quad |
| bond_req | input | 1 | Transmit and receive may deliberately share a PLL |
| cfg_valid | output | 1 | One-cycle pulse when a new result is loaded |
| freq_count | output | CNT_W | TMDS edges counted in the last window |
| ref_div | output | 2 | PLL reference divider |
| vco_mult | output | 7 | PLL VCO multiplier, 0 when unsupported |
| dru_en | output | 1 | Oversampling recovery path enabled |
| dru_rate_mbps | output | 12 | Recovery path line rate in Mb/s, 0 when disabled |
| unsupported | output | 1 | Frequency is in a gap or out of range |
| sel_conflict | output | 1 | Both directions on one PLL without a bonding request |
| tx_dru_reject | output | 1 | Bonded mode, and the current format needs the recovery path |

## Verification
The assertions assume that `rx_pll_sel` is held steady for the whole measurement window whose result they examine. They also assume that the TMDS clock keeps a fixed frequency well inside the counter's range, so one window's count cannot wrap the free-running counter. The stimulus only changes the frequency or the PLL kind between results. It then discards the first result after every change and judges only the second, which covers a whole window at the new setting. Test frequencies sit a few counts clear of each range boundary, so the edge-count quantization of ±1 cannot push a point into the neighbouring range.

// File: rtl/tmds_pll_pkg.sv
package tmds_pll_pkg;

   typedef enum logic {
      PLL_CHAN = 1'b0,
      PLL_QUAD = 1'b1
   } pll_kind_e;

   typedef struct packed {
      logic [1:0]  ref_div;
      logic [6:0]  mult;
      logic        dru_en;
      logic [11:0] rate;
      logic        unsup;
   } pll_cfg_t;

   localparam pll_cfg_t CFG_NONE = '{ref_div: 2'd1, mult: 7'd0, dru_en: 1'b0,
                                      rate: 12'd0, unsup: 1'b1};

   // Converts a frequency in kHz to an edge count per window.
   function automatic longint unsigned khz2cnt(input longint unsigned khz,
                                                input longint unsigned win,
                                                input longint unsigned refk);
      return (khz * win) / refk;
   endfunction

endpackage

// File: rtl/tpcs_freq_meter.sv
module tpcs_freq_meter #(
   parameter int CNT_W       = 20,
   parameter int WINDOW      = 100000,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk_ref,
   input  logic             clk_tmds,
   input  logic             rst_n,
   output logic [CNT_W-1:0] meas_count,
   output logic             meas_vld
);
   localparam int WIN_W = $clog2(WINDOW);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (WINDOW < 2) begin : g_bad_win
      $error("WINDOW must be at least 2");
   end

   // TMDS domain: binary counter with registered Gray image
   logic [CNT_W-1:0] bin_t, bin_nxt, gray_t;
   assign bin_nxt = bin_t + 1'b1;

   always_ff @(posedge clk_tmds or negedge rst_n) begin
      if (!rst_n) begin
         bin_t  <= '0;
         gray_t <= '0;
      end else begin
         bin_t  <= bin_nxt;
         gray_t <= bin_nxt ^ (bin_nxt >> 1);
      end
   end

   // Reference domain synchronizer chain
   logic [CNT_W-1:0] sync_q [SYNC_STAGES];

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk_ref or negedge rst_n) begin
         if (!rst_n) sync_q[s] <= '0;
         else if (s == 0) sync_q[s] <= gray_t;
         else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
   end

   logic [CNT_W-1:0] gray_r, bin_r, prev_r;
   assign gray_r = sync_q[SYNC_STAGES-1];

   always_comb begin
      bin_r[CNT_W-1] = gray_r[CNT_W-1];
      for (int i = CNT_W-2; i >= 0; i--) bin_r[i] = bin_r[i+1] ^ gray_r[i];
   end

   logic [WIN_W-1:0] win_cnt;
   logic             win_end;
   assign win_end = (win_cnt == WIN_W'(WINDOW-1));

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         win_cnt    <= '0;
         prev_r     <= '0;
         meas_count <= '0;
         meas_vld   <= 1'b0;
      end else begin
         meas_vld <= win_end;
         if (win_end) begin
            win_cnt    <= '0;
            prev_r     <= bin_r;
            meas_count <= bin_r - prev_r;
         end else begin
            win_cnt <= win_cnt + 1'b1;
         end
      end
   end

   // R2: a measurement strobe never lasts two cycles
   p_meas_pulse_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
      meas_vld |=> !meas_vld);

endmodule

// File: rtl/tpcs_range_map.sv
module tpcs_range_map
   import tmds_pll_pkg::*;
#(
   parameter int CNT_W   = 20,
   parameter int WINDOW  = 100000,
   parameter int REF_KHZ = 100000
) (
   input  logic [CNT_W-1:0] count,
   input  pll_kind_e        kind,
   output pll_cfg_t         cfg
);
   localparam logic [CNT_W-1:0] C_080 = CNT_W'(khz2cnt(80000,  WINDOW, REF_KHZ));
   localparam logic [CNT_W-1:0] C_165 = CNT_W'(khz2cnt(165000, WINDOW, REF_KHZ));
   localparam logic [CNT_W-1:0] C_330 = CNT_W'(khz2cnt(330000, WINDOW, REF_KHZ));
   localparam logic [CNT_W-1:0] Q_074 = CNT_W'(khz2cnt(74125,  WINDOW, REF_KHZ));
   localparam logic [CNT_W-1:0] Q_100 = CNT_W'(khz2cnt(100000, WINDOW, REF_KHZ));
   localparam logic [CNT_W-1:0] Q_148 = CNT_W'(khz2cnt(148250, WINDOW, REF_KHZ));
   localparam logic [CNT_W-1:0] Q_200 = CNT_W'(khz2cnt(200000, WINDOW, REF_KHZ));
   localparam logic [CNT_W-1:0] Q_296 = CNT_W'(khz2cnt(296500, WINDOW, REF_KHZ));
   localparam logic [CNT_W-1:0] Q_400 = CNT_W'(khz2cnt(400000, WINDOW, REF_KHZ));

   function automatic pll_cfg_t mk(input int div, input int mul);
      pll_cfg_t c;
      c.ref_div = 2'(div);
      c.mult    = 7'(mul);
      c.dru_en  = 1'b0;
      c.rate    = '0;
      c.unsup   = 1'b0;
      return c;
   endfunction

   always_comb begin
      cfg = CFG_NONE;
      if (kind == PLL_CHAN) begin
         if (count < C_080) begin
            cfg        = mk(2, 20);
            cfg.dru_en = 1'b1;
            cfg.rate   = 12'd2500;
         end else if (count < C_165) cfg = mk(1, 20);
         else if (count < C_330)     cfg = mk(1, 10);
      end else begin
         if (count < Q_074) begin
            cfg        = mk(1, 40);
            cfg.dru_en = 1'b1;
            cfg.rate   = 12'd2000;
         end else if (count < Q_100)                   cfg = mk(1, 80);
         else if (count >= Q_148 && count < Q_200)     cfg = mk(1, 40);
         else if (count >= Q_296 && count < Q_400)     cfg = mk(1, 20);
      end
   end

endmodule

// File: rtl/tmds_pll_select.sv
module tmds_pll_select
   import tmds_pll_pkg::*;
#(
   parameter int CNT_W       = 20,
   parameter int WINDOW      = 100000,
   parameter int REF_KHZ     = 100000,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk_ref,
   input  logic             rst_n,
   input  logic             clk_tmds,
   input  logic             rx_pll_sel,
   input  logic             tx_pll_sel,
   input  logic             bond_req,
   output logic             cfg_valid,
   output logic [CNT_W-1:0] freq_count,
   output logic [1:0]       ref_div,
   output logic [6:0]       vco_mult,
   output logic             dru_en,
   output logic [11:0]      dru_rate_mbps,
   output logic             unsupported,
   output logic             sel_conflict,
   output logic             tx_dru_reject
);
   // Counter must hold twice the highest count of interest without wrap
   localparam longint unsigned MAX_CNT = khz2cnt(800000, WINDOW, REF_KHZ);
   if (MAX_CNT >= (64'd1 << CNT_W)) begin : g_bad_width
      $error("CNT_W too small for WINDOW and REF_KHZ");
   end

   logic [CNT_W-1:0] meas_count;
   logic             meas_vld;
   pll_cfg_t         cfg_next, cfg_q;
   pll_kind_e        kind_q;

   tpcs_freq_meter #(.CNT_W(CNT_W), .WINDOW(WINDOW), .SYNC_STAGES(SYNC_STAGES)) u_meter (
      .clk_ref    (clk_ref),
      .clk_tmds   (clk_tmds),
      .rst_n      (rst_n),
      .meas_count (meas_count),
      .meas_vld   (meas_vld)
   );

   tpcs_range_map #(.CNT_W(CNT_W), .WINDOW(WINDOW), .REF_KHZ(REF_KHZ)) u_map (
      .count (meas_count),
      .kind  (pll_kind_e'(rx_pll_sel)),
      .cfg   (cfg_next)
   );

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q      <= CFG_NONE;
         kind_q     <= PLL_CHAN;
         freq_count <= '0;
         cfg_valid  <= 1'b0;
      end else begin
         cfg_valid <= meas_vld;
         if (meas_vld) begin
            cfg_q      <= cfg_next;
            kind_q     <= pll_kind_e'(rx_pll_sel);
            freq_count <= meas_count;
         end
      end
   end

   assign ref_div       = cfg_q.ref_div;
   assign vco_mult      = cfg_q.mult;
   assign dru_en        = cfg_q.dru_en;
   assign dru_rate_mbps = cfg_q.rate;
   assign unsupported   = cfg_q.unsup;

   logic same_pll;
   assign same_pll      = (tx_pll_sel == rx_pll_sel);
   assign sel_conflict  = same_pll && !bond_req;
   assign tx_dru_reject = same_pll && bond_req && cfg_q.dru_en;

   // Independent thresholds for the checks below
   localparam logic [CNT_W-1:0] A_C080 = CNT_W'(khz2cnt(80000,  WINDOW, REF_KHZ));
   localparam logic [CNT_W-1:0] A_Q100 = CNT_W'(khz2cnt(100000, WINDOW, REF_KHZ));
   localparam logic [CNT_W-1:0] A_Q148 = CNT_W'(khz2cnt(148250, WINDOW, REF_KHZ));
   localparam logic [CNT_W-1:0] A_Q200 = CNT_W'(khz2cnt(200000, WINDOW, REF_KHZ));
   localparam logic [CNT_W-1:0] A_Q296 = CNT_W'(khz2cnt(296500, WINDOW, REF_KHZ));

   p_valid_pulse_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
      cfg_valid |=> !cfg_valid);

   p_hold_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !cfg_valid |-> ($stable(vco_mult) && $stable(ref_div) && $stable(dru_en)
                      && $stable(unsupported) && $stable(freq_count)));

   p_chan_low_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (cfg_valid && kind_q == PLL_CHAN && freq_count < A_C080)
         |-> (dru_en && ref_div == 2'd2 && vco_mult == 7'd20));

   p_quad_gap_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (cfg_valid && kind_q == PLL_QUAD &&
       ((freq_count >= A_Q100 && freq_count < A_Q148) ||
        (freq_count >= A_Q200 && freq_count < A_Q296))) |-> unsupported);

   p_unsup_clean_r9: assert property (@(posedge clk_ref) disable iff (!rst_n)
      unsupported |-> (vco_mult == 7'd0 && !dru_en && dru_rate_mbps == 12'd0));

   p_bond_reject_r11: assert property (@(posedge clk_ref) disable iff (!rst_n)
      tx_dru_reject |-> (!sel_conflict && !unsupported && dru_rate_mbps != 12'd0));

endmodule

// File: tb/tmds_pll_select_tb.sv
`timescale 1ns/1ps
module tmds_pll_select_tb;
   localparam int CNT_W   = 20;
   localparam int WINDOW  = 2000;
   localparam int REF_KHZ = 200000;

   typedef struct packed {
      int          f_khz;
      logic        quad;
      logic [1:0]  div;
      logic [6:0]  mult;
      logic        dru;
      logic [11:0] rate;
      logic        unsup;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VEC [NV] = '{
      '{50000,  1'b0, 2'd2, 7'd20, 1'b1, 12'd2500, 1'b0},
      '{80300,  1'b0, 2'd1, 7'd20, 1'b0, 12'd0,    1'b0},
      '{120000, 1'b0, 2'd1, 7'd20, 1'b0, 12'd0,    1'b0},
      '{164000, 1'b0, 2'd1, 7'd20, 1'b0, 12'd0,    1'b0},
      '{166000, 1'b0, 2'd1, 7'd10, 1'b0, 12'd0,    1'b0},
      '{250000, 1'b0, 2'd1, 7'd10, 1'b0, 12'd0,    1'b0},
      '{329000, 1'b0, 2'd1, 7'd10, 1'b0, 12'd0,    1'b0},
      '{340000, 1'b0, 2'd1, 7'd0,  1'b0, 12'd0,    1'b1},
      '{60000,  1'b1, 2'd1, 7'd40, 1'b1, 12'd2000, 1'b0},
      '{74600,  1'b1, 2'd1, 7'd80, 1'b0, 12'd0,    1'b0},
      '{90000,  1'b1, 2'd1, 7'd80, 1'b0, 12'd0,    1'b0},
      '{101000, 1'b1, 2'd1, 7'd0,  1'b0, 12'd0,    1'b1},
      '{120000, 1'b1, 2'd1, 7'd0,  1'b0, 12'd0,    1'b1},
      '{150000, 1'b1, 2'd1, 7'd40, 1'b0, 12'd0,    1'b0},
      '{199000, 1'b1, 2'd1, 7'd40, 1'b0, 12'd0,    1'b0},
      '{250000, 1'b1, 2'd1, 7'd0,  1'b0, 12'd0,    1'b1},
      '{300000, 1'b1, 2'd1, 7'd20, 1'b0, 12'd0,    1'b0},
      '{390000, 1'b1, 2'd1, 7'd20, 1'b0, 12'd0,    1'b0},
      '{410000, 1'b1, 2'd1, 7'd0,  1'b0, 12'd0,    1'b1}
   };

   logic clk = 1'b0;
   logic clk_tmds = 1'b0;
   logic rst_n = 1'b0;
   logic rx_pll_sel = 1'b0, tx_pll_sel = 1'b1, bond_req = 1'b0;
   logic             cfg_valid, dru_en, unsupported, sel_conflict, tx_dru_reject;
   logic [CNT_W-1:0] freq_count;
   logic [1:0]       ref_div;
   logic [6:0]       vco_mult;
   logic [11:0]      dru_rate_mbps;
   real half_ns = 10.0;
   int  n_chk = 0, n_bad = 0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;
   initial forever #(half_ns) clk_tmds = ~clk_tmds;

   tmds_pll_select #(.CNT_W(CNT_W), .WINDOW(WINDOW), .REF_KHZ(REF_KHZ)) u_dut (
      .clk_ref(clk), .rst_n(rst_n), .clk_tmds(clk_tmds),
      .rx_pll_sel(rx_pll_sel), .tx_pll_sel(tx_pll_sel), .bond_req(bond_req),
      .cfg_valid(cfg_valid), .freq_count(freq_count), .ref_div(ref_div),
      .vco_mult(vco_mult), .dru_en(dru_en), .dru_rate_mbps(dru_rate_mbps),
      .unsupported(unsupported), .sel_conflict(sel_conflict),
      .tx_dru_reject(tx_dru_reject));

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_near(input string req, input longint act, input longint exp);
      n_chk++;
      if (act > exp + 2 || act + 2 < exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d(+-2)", req, act, exp);
      end
   endtask

   task automatic set_freq(input int f_khz);
      half_ns = 500000.0 / real'(f_khz);
   endtask

   task automatic wait_result();
      @(negedge clk);
      while (!cfg_valid) @(negedge clk);
   endtask

   task automatic settle();
      wait_result();
      wait_result();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      set_freq(120000);
      repeat (5) @(negedge clk);
      // R1: reset state
      chk("R1 valid", cfg_valid, 0);
      chk("R1 count", freq_count, 0);
      chk("R1 unsup", unsupported, 1);
      chk("R1 dru", dru_en, 0);
      chk("R1 mult", vco_mult, 0);
      chk("R1 div", ref_div, 1);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      chk("R1 after release", unsupported, 1);
      chk("R1 rate", dru_rate_mbps, 0);

      // Vector table walk
      for (int v = 0; v < NV; v++) begin
         rx_pll_sel = VEC[v].quad;
         tx_pll_sel = ~VEC[v].quad;
         set_freq(VEC[v].f_khz);
         settle();
         chk_near("R2 count", freq_count, VEC[v].f_khz / 100);
         chk(VEC[v].quad ? "R6 R7 R8 div" : "R3 R4 R5 div", ref_div, VEC[v].div);
         chk(VEC[v].quad ? "R6 R7 R8 mult" : "R3 R4 R5 mult", vco_mult, VEC[v].mult);
         chk("R3 R8 dru", dru_en, VEC[v].dru);
         chk("R3 R8 rate", dru_rate_mbps, VEC[v].rate);
         chk("R5 R7 R9 unsup", unsupported, VEC[v].unsup);
         chk("R10 no conflict", sel_conflict, 0);
         chk("R11 no reject", tx_dru_reject, 0);
      end

      // R2: pulse width and hold between pulses
      set_freq(90000);
      rx_pll_sel = 1'b1;
      settle();
      @(negedge clk);
      chk("R2 pulse width", cfg_valid, 0);
      repeat (WINDOW / 2) @(negedge clk);
      chk("R2 hold mult", vco_mult, 80);
      chk_near("R2 hold count", freq_count, 900);
      // R2: changing the PLL kind mid-window does not alter held outputs
      rx_pll_sel = 1'b0;
      repeat (10) @(negedge clk);
      chk("R2 hold after sel change", vco_mult, 80);

      // R10: conflict encoding
      tx_pll_sel = 1'b0; rx_pll_sel = 1'b0; bond_req = 1'b0;
      @(negedge clk);
      chk("R10 same no bond", sel_conflict, 1);
      bond_req = 1'b1;
      @(negedge clk);
      chk("R10 same bonded", sel_conflict, 0);
      tx_pll_sel = 1'b1; bond_req = 1'b0;
      @(negedge clk);
      chk("R10 differ", sel_conflict, 0);

      // R11: bonded and low-rate format
      tx_pll_sel = 1'b0; rx_pll_sel = 1'b0; bond_req = 1'b1;
      set_freq(50000);
      settle();
      chk("R11 reject low", tx_dru_reject, 1);
      chk("R3 bonded dru", dru_en, 1);
      set_freq(120000);
      settle();
      chk("R11 no reject native", tx_dru_reject, 0);
      bond_req = 1'b0;
      set_freq(50000);
      settle();
      chk("R11 unbonded no reject", tx_dru_reject, 0);

      // R4: just above the 165 MHz boundary goes to the higher range
      set_freq(165300);
      settle();
      chk("R4 boundary mult", vco_mult, 10);

      // R1: reset mid-run restores the reset state
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 re-reset unsup", unsupported, 1);
      chk("R1 re-reset dru", dru_en, 0);
      finish_run();
   end
endmodule